// File: doc/BRIEF.md
# External Interrupt and Event Controller

This block watches a group of external input lines and turns selected edges on them into two kinds of output for each line. The first is a latched pending flag that stays set until software clears it; the OR of all pending flags forms a single interrupt request toward the interrupt controller. The second is a one-clock event pulse, meant for waking a core that waits for events rather than taking interrupts. Both outputs come from the same per-line trigger: a detected edge, or a software request. Each path then has its own enable mask.

Each input line passes through a two-flop synchroniser. The synchronised value is then compared with its value one clock earlier. Per-line rise and fall selects decide which transitions count as triggers. Software can also raise any line through a set-only software request register. Six registers are reached through an APB slave.

The APB side has no back-pressure. `pready` is tied high, so every access finishes in its access phase with no wait states. Read data is valid during that phase.

Top module: `ext_irq_evt_ctrl`

## Requirements
- R1: After reset, all six registers read 0, `irq_o` is low and `evt_o` is all zeros.
- R2: Register map, by byte offset:
  - 0x00: interrupt enable mask.
  - 0x04: event enable mask.
  - 0x08: rise select.
  - 0x0C: fall select.
  - 0x10: software request.
  - 0x14: pending.

  Bit i of each register belongs to line i. Bits N and above read 0. Any other offset reads 0 and ignores writes. `pready` is always 1.
- R3: A line change applied before clock edge E1 is seen as an edge at edge E3. The line's pending flag is set after E3 and not after E2. Only transitions enabled in the line's rise select or fall select register count; with both enabled, both directions count.
- R4: A trigger sets the pending flag only when the line's interrupt enable bit is 1.
- R5: In the pending register, writing 1 to a bit clears that pending flag and the line's software request bit. Writing 0 has no effect. A trigger in the same cycle as a clear wins, and the flag stays set.
- R6: `irq_o` is high exactly while any pending flag is set. It stays high until every flag is cleared.
- R7: Each trigger on a line whose event enable bit is 1 gives a pulse on `evt_o[i]` lasting exactly one clock. The pulse appears in the same cycle the pending flag would be set, whatever the interrupt enable bit is.
- R8: Writing 1 to a software request bit that is 0 sets it, and this counts as one trigger for that line. Writing 1 to a bit that is already set, or writing 0, does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | AW (5) | APB byte address |
| pwdata | input | DW (32) | APB write data |
| prdata | output | DW (32) | APB read data |
| pready | output | 1 | APB ready, always high |
| lines_i | input | N (10) | External input lines, asynchronous |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | N (10) | Per-line event pulses |

## Verification
The single-pulse check on `evt_o` assumes that an input line holds each level for at least two clocks. It also assumes that a software request for a line does not land in the cycle right after an edge on that same line; otherwise two true triggers would give back-to-back pulses. The directed tasks keep every line level for several clocks and issue software requests only on idle lines. APB accesses always use a setup phase followed by one access phase, with aligned addresses.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned IDX_W = 3;
  typedef enum logic [IDX_W-1:0] {
    SEL_IMASK = 3'd0,
    SEL_EMASK = 3'd1,
    SEL_RISE  = 3'd2,
    SEL_FALL  = 3'd3,
    SEL_SWREQ = 3'd4,
    SEL_PEND  = 3'd5
  } eic_reg_e;
endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
  parameter int N      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], lines_i[g]};
    end
    assign edge_o[g] = ( sh[STAGES-1] & ~sh[STAGES] & rise_en_i[g]) |
                       (~sh[STAGES-1] &  sh[STAGES] & fall_en_i[g]);
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int N  = 10,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic [N-1:0]  edge_i,
  output logic [N-1:0]  imask_o,
  output logic [N-1:0]  emask_o,
  output logic [N-1:0]  rise_o,
  output logic [N-1:0]  fall_o,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  trig_o
);
  localparam int TOP_SHIFT = IDX_W + 2;

  logic [N-1:0] imask_q, emask_q, rise_q, fall_q, swreq_q, pend_q;
  logic [N-1:0] wdat, sw_set, pend_clr, rdat;
  logic         wr, hit;
  eic_reg_e     idx;

  assign idx  = eic_reg_e'(paddr[2 +: IDX_W]);
  assign hit  = (paddr[1:0] == 2'b00) && ((paddr >> TOP_SHIFT) == '0);
  assign wr   = psel && penable && pwrite && hit;
  assign wdat = pwdata[N-1:0];

  // a software request counts only when a bit goes from 0 to 1
  assign sw_set   = (wr && idx == SEL_SWREQ) ? (wdat & ~swreq_q) : '0;
  assign pend_clr = (wr && idx == SEL_PEND)  ? wdat : '0;
  assign trig_o   = edge_i | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      swreq_q <= '0;
      pend_q  <= '0;
    end else begin
      if (wr && idx == SEL_IMASK) imask_q <= wdat;
      if (wr && idx == SEL_EMASK) emask_q <= wdat;
      if (wr && idx == SEL_RISE)  rise_q  <= wdat;
      if (wr && idx == SEL_FALL)  fall_q  <= wdat;
      swreq_q <= (swreq_q | sw_set) & ~pend_clr;
      // a new trigger outranks a clear in the same cycle
      pend_q  <= (pend_q & ~pend_clr) | (trig_o & imask_q);
    end
  end

  always_comb begin
    rdat = '0;
    if (hit) begin
      case (idx)
        SEL_IMASK: rdat = imask_q;
        SEL_EMASK: rdat = emask_q;
        SEL_RISE:  rdat = rise_q;
        SEL_FALL:  rdat = fall_q;
        SEL_SWREQ: rdat = swreq_q;
        SEL_PEND:  rdat = pend_q;
        default:   rdat = '0;
      endcase
    end
  end

  assign prdata  = DW'(rdat);
  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/eic_pulse_gen.sv
module eic_pulse_gen #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pulse_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= '0;
    else        pulse_o <= trig_i & mask_i;
  end
endmodule

// File: rtl/ext_irq_evt_ctrl.sv
module ext_irq_evt_ctrl #(
  parameter int N  = 10,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  input  logic [N-1:0]  lines_i,
  output logic          irq_o,
  output logic [N-1:0]  evt_o
);
  logic [N-1:0] edge_w, imask_w, emask_w, rise_w, fall_w, pend_w, trig_w;

  eic_sync_edge #(.N(N), .STAGES(2)) u_edge (
    .clk(pclk), .rst_n(presetn), .lines_i(lines_i),
    .rise_en_i(rise_w), .fall_en_i(fall_w), .edge_o(edge_w)
  );

  eic_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .edge_i(edge_w), .imask_o(imask_w), .emask_o(emask_w),
    .rise_o(rise_w), .fall_o(fall_w), .pend_o(pend_w), .trig_o(trig_w)
  );

  eic_pulse_gen #(.N(N)) u_pulse (
    .clk(pclk), .rst_n(presetn), .trig_i(trig_w), .mask_i(emask_w),
    .pulse_o(evt_o)
  );

  assign pready = 1'b1;
  assign irq_o  = |pend_w;
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int N  = 10,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] prdata,
  input logic [N-1:0]  imask,
  input logic [N-1:0]  emask,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  evt,
  input logic          irq
);
  logic clr_wr;
  assign clr_wr = psel && penable && pwrite && (paddr == AW'(8'h14));

  // R5: without a clear write, no pending flag falls
  a_r5_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((pend & $past(pend)) == $past(pend)));

  // R6: the request stays up until software writes the pending register
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  // R4: a flag can only rise on a line whose interrupt enable was set
  a_r4_pend_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(imask)) == '0);

  // R7: an event pulse needs the line's event enable
  a_r7_evt_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~$past(emask)) == '0);

  // R7: a pulse lasts a single clock
  a_r7_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((evt & $past(evt)) == '0));

  // R2: unused upper read bits are zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (prdata >> N) == '0);
endmodule

bind ext_irq_evt_ctrl eic_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .imask(imask_w),
  .emask(emask_w), .pend(pend_w), .evt(evt_o), .irq(irq_o)
);

// File: tb/test_ext_irq_evt_ctrl.sv
module test_ext_irq_evt_ctrl;
  localparam int N  = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_IM = 5'h00, A_EM = 5'h04, A_RS = 5'h08,
                            A_FS = 5'h0C, A_SW = 5'h10, A_PD = 5'h14;

  logic pclk = 1'b0, presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [N-1:0]  lines = '0;
  logic [DW-1:0] prdata;
  logic          pready, irq;
  logic [N-1:0]  evt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 pclk = ~pclk;

  ext_irq_evt_ctrl #(.N(N), .AW(AW), .DW(DW)) i_ext_irq_evt_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .lines_i(lines), .irq_o(irq), .evt_o(evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; d = prdata;
    chk("R2 pready", 32'(pready), 32'd1);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [DW-1:0] d;
    apb_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic watch(input int n, output logic [N-1:0] seen);
    seen = '0;
    repeat (n) begin @(negedge pclk); seen |= evt; end
  endtask

  task automatic cleanup();
    apb_wr(A_IM, 0); apb_wr(A_EM, 0); apb_wr(A_RS, 0); apb_wr(A_FS, 0);
    apb_wr(A_PD, 32'h3FF);
    lines = '0;
    repeat (4) @(negedge pclk);
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq), 0);
    chk("R1 evt", 32'(evt), 0);
    rd_chk("R1 imask", A_IM, 0); rd_chk("R1 emask", A_EM, 0);
    rd_chk("R1 rise", A_RS, 0);  rd_chk("R1 fall", A_FS, 0);
    rd_chk("R1 swreq", A_SW, 0); rd_chk("R1 pend", A_PD, 0);
  endtask

  task automatic t_regs();
    apb_wr(A_IM, 32'hFFFF_FFFF); rd_chk("R2 imask upper", A_IM, 32'h3FF);
    apb_wr(A_EM, 32'h155);       rd_chk("R2 emask", A_EM, 32'h155);
    apb_wr(A_RS, 32'h2AA);       rd_chk("R2 rise", A_RS, 32'h2AA);
    apb_wr(A_FS, 32'h0F0);       rd_chk("R2 fall", A_FS, 32'h0F0);
    apb_wr(5'h18, 32'h3FF);      rd_chk("R2 unmapped 0x18", 5'h18, 0);
    rd_chk("R2 unmapped 0x1C", 5'h1C, 0);
    rd_chk("R2 imask kept", A_IM, 32'h3FF);
    cleanup();
  endtask

  task automatic t_rise();
    logic [N-1:0] s;
    apb_wr(A_IM, 1); apb_wr(A_EM, 1); apb_wr(A_RS, 1);
    @(negedge pclk); lines[0] = 1;
    repeat (2) @(posedge pclk); @(negedge pclk);
    chk("R3 not yet after E2", 32'(irq), 0);
    @(posedge pclk); @(negedge pclk);
    chk("R3 irq after E3", 32'(irq), 1);
    chk("R7 pulse on", 32'(evt), 32'h1);
    @(negedge pclk);
    chk("R7 pulse one clock", 32'(evt), 0);
    rd_chk("R3 pend line0", A_PD, 32'h1);
    @(negedge pclk); lines[0] = 0;
    watch(6, s);
    chk("R3 fall not selected", 32'(s), 0);
    rd_chk("R3 pend unchanged", A_PD, 32'h1);
    cleanup();
  endtask

  task automatic t_fall();
    logic [N-1:0] s;
    apb_wr(A_IM, 2); apb_wr(A_EM, 2); apb_wr(A_FS, 2);
    @(negedge pclk); lines[1] = 1;
    watch(6, s);
    chk("R3 rise not selected", 32'(s), 0);
    rd_chk("R3 pend none", A_PD, 0);
    @(negedge pclk); lines[1] = 0;
    watch(6, s);
    chk("R3 fall event", 32'(s), 32'h2);
    rd_chk("R3 fall pend", A_PD, 32'h2);
    cleanup();
  endtask

  task automatic t_both();
    logic [N-1:0] s;
    apb_wr(A_IM, 4); apb_wr(A_EM, 4); apb_wr(A_RS, 4); apb_wr(A_FS, 4);
    @(negedge pclk); lines[2] = 1;
    watch(6, s);
    chk("R3 both rise", 32'(s), 32'h4);
    rd_chk("R3 both rise pend", A_PD, 32'h4);
    apb_wr(A_PD, 32'h4);
    rd_chk("R5 cleared", A_PD, 0);
    @(negedge pclk); lines[2] = 0;
    watch(6, s);
    chk("R3 both fall", 32'(s), 32'h4);
    rd_chk("R3 both fall pend", A_PD, 32'h4);
    cleanup();
  endtask

  task automatic t_masks();
    logic [N-1:0] s;
    apb_wr(A_EM, 32'h008); apb_wr(A_IM, 32'h010); apb_wr(A_RS, 32'h018);
    @(negedge pclk); lines[3] = 1; lines[4] = 1;
    watch(6, s);
    chk("R7 event only on emask line", 32'(s), 32'h008);
    rd_chk("R4 pend only on imask line", A_PD, 32'h010);
    chk("R6 irq high", 32'(irq), 1);
    cleanup();
  endtask

  task automatic t_clear();
    logic [N-1:0] s;
    apb_wr(A_IM, 32'h180); apb_wr(A_RS, 32'h180);
    @(negedge pclk); lines[7] = 1; lines[8] = 1;
    watch(6, s);
    rd_chk("R5 two set", A_PD, 32'h180);
    apb_wr(A_PD, 0);
    rd_chk("R5 write zero ignored", A_PD, 32'h180);
    apb_wr(A_PD, 32'h080);
    rd_chk("R5 clear one", A_PD, 32'h100);
    chk("R6 irq while one left", 32'(irq), 1);
    apb_wr(A_PD, 32'h100);
    rd_chk("R5 clear last", A_PD, 0);
    chk("R6 irq low when all clear", 32'(irq), 0);
    cleanup();
  endtask

  task automatic t_sw();
    logic [N-1:0] s;
    apb_wr(A_IM, 32'h20); apb_wr(A_EM, 32'h20);
    apb_wr(A_SW, 32'h20);
    chk("R8 sw pulse", 32'(evt), 32'h20);
    chk("R8 sw irq", 32'(irq), 1);
    watch(3, s);
    chk("R8 single pulse", 32'(s), 0);
    rd_chk("R8 swreq set", A_SW, 32'h20);
    rd_chk("R8 pend set", A_PD, 32'h20);
    apb_wr(A_SW, 32'h20);
    chk("R8 rewrite no pulse", 32'(evt), 0);
    apb_wr(A_SW, 0);
    rd_chk("R8 zero ignored", A_SW, 32'h20);
    apb_wr(A_PD, 32'h20);
    rd_chk("R5 clears swreq", A_SW, 0);
    rd_chk("R5 pend clear", A_PD, 0);
    apb_wr(A_SW, 32'h20);
    chk("R8 retrigger after clear", 32'(evt), 32'h20);
    cleanup();
  endtask

  task automatic t_collide();
    logic [N-1:0] s;
    apb_wr(A_IM, 32'h40); apb_wr(A_RS, 32'h40); apb_wr(A_FS, 32'h40);
    @(negedge pclk); lines[6] = 1;
    watch(6, s);
    rd_chk("R5 pre-set", A_PD, 32'h40);
    @(negedge pclk); lines[6] = 0;
    @(negedge pclk); psel = 1; pwrite = 1; paddr = A_PD; pwdata = 32'h40; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    rd_chk("R5 trigger beats clear", A_PD, 32'h40);
    apb_wr(A_PD, 32'h40);
    rd_chk("R5 plain clear", A_PD, 0);
    cleanup();
  endtask

  initial begin
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_both();
    t_masks();
    t_clear();
    t_sw();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule